// File: doc/BRIEF.md
# Serial Audio Frame Synchroniser and Descrambler

This block takes the recovered 728 kbit/s digital sound bit stream, one bit per cycle in which `bit_en` is high. It hunts for the 8-bit alignment pattern and confirms it one frame later. Once the pattern is confirmed, it keeps frame timing through isolated missing patterns. While it holds lock, it strips the pseudo-random scrambling from every bit between two alignment patterns. It captures the control bits and tracks the 16-frame cycle of the frame flag. It cuts the sample area into 11-bit words and checks the parity of each word. A word that fails parity is replaced by the last good word of the same channel.

Frame timing is set by a three-state machine:
- SEARCH moves to VERIFY ("first sighting") when the last 8 received bits equal the alignment pattern.
- VERIFY moves to LOCKED ("confirmed") when the pattern is present again exactly one frame later.
- VERIFY falls back to SEARCH ("false start") when that pattern is absent.
- LOCKED moves to SEARCH ("lost") on the third consecutive absent pattern. A present pattern resets the miss count ("held").

Downstream logic takes the sample words, the per-word error flag and a per-frame error total.

Top module: `nicam_frame_sync`

## Requirements
- R1: In SEARCH, the last 8 received bits are compared on every bit against the pattern 0100_1110, with the first received bit leftmost. A match makes the next bit payload position 0 of a 728-bit frame, so frames may start at any bit offset.
- R2: Lock (`lock_o` high) is declared when the pattern is found again exactly 728 bits after the first sighting. It holds from the next payload bit on.
- R3: While locked, one or two consecutive missing patterns keep lock, and a present pattern clears the miss count. The third consecutive miss drops lock before the next frame's payload.
- R4: While locked, each of the 720 payload bits is XORed with a PRBS bit. The PRBS is a 9-stage register reloaded to all ones at payload position 0. Its output is stage 9, and it shifts by one with stage 9 XOR stage 4 entering stage 1. Without lock, no samples are produced.
- R5: The descrambled payload holds, in this order: 5 control bits (the frame flag first, output on `ctrl_bits[0]`, the others on bits 1 to 4), then 11 ignored bits, then 64 words of 11 bits. Each word arrives first bit first and becomes bits 10 down to 0 of the word. Words alternate channel 0 (even words) and channel 1 (odd words). Each word gives a single-cycle `smp_valid` pulse.
- R6: A word whose 11 bits have odd parity (bit 0 being the parity bit) is a parity error, and `smp_perr` is high with its `smp_valid` pulse.
- R7: A word with a parity error is replaced on `smp_word` by the last good word of its channel. This holds across frame boundaries. After reset, the last good word is 0.
- R8: `frm_errs` is loaded, on the last word of each locked frame, with that frame's parity-error count including the last word. It holds until the next frame's last word.
- R9: On each locked frame, `frame_phase` resets to 0 if the flag is 1 after 0 on the previous frame, and otherwise counts modulo 16. `flag_sync` rises on that 0-to-1 change. It falls when the flag differs from (phase < 8), or when lock is absent.
- R10: After reset: SEARCH, `lock_o`, `flag_sync`, `smp_valid` and `smp_perr` low, and `frame_phase`, `ctrl_bits` and `frm_errs` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | High in cycles that carry a stream bit |
| bit_in | input | 1 | Stream bit |
| lock_o | output | 1 | Frame lock held |
| flag_sync | output | 1 | Frame flag cycle confirmed |
| frame_phase | output | 4 | Position in the 16-frame flag cycle |
| ctrl_bits | output | 5 | Descrambled control bits, flag in bit 0 |
| smp_valid | output | 1 | Sample word strobe |
| smp_chan | output | 1 | Channel of the word (0 or 1) |
| smp_word | output | 11 | Sample word, concealed on error |
| smp_perr | output | 1 | Parity error on this word |
| frm_errs | output | 7 | Parity errors in the last locked frame |

## Verification
The last word of a frame completes on the same bit that closes the frame error total. The total must therefore take in that word's own error flag. The bench injects a parity error into word 63, together with words 0 and 31, and expects the total of three, with no error dropped or counted twice. Concealment and relock also meet: after lock is lost and regained, a failing word 0 must repeat the good word kept from before the loss, or 0 when a reset came in between.

// File: rtl/nicam_fs_pkg.sv
package nicam_fs_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } sync_state_e;
endpackage

// File: rtl/nicam_align_tracker.sv
module nicam_align_tracker
    import nicam_fs_pkg::*;
#(
    parameter int FRAME_BITS = 728,
    parameter int ALIGN_W    = 8,
    parameter logic [ALIGN_W-1:0] ALIGN_PAT = 8'h4E,
    parameter int LOCK_HITS  = 2,
    parameter int LOSS_MISS  = 3,
    parameter int POS_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic             locked,
    output logic [POS_W-1:0] pos
);
    localparam int CNT_W = $clog2(LOCK_HITS + LOSS_MISS + 1);

    sync_state_e        st_q, st_d;
    logic [ALIGN_W-1:0] win_q;
    logic [POS_W-1:0]   pos_q;
    logic [CNT_W-1:0]   hits_q, miss_q;
    logic [ALIGN_W-1:0] win_nx;
    logic               hit, frame_end;

    assign win_nx    = {win_q[ALIGN_W-2:0], bit_in};
    assign hit       = (win_nx == ALIGN_PAT);
    assign frame_end = (pos_q == POS_W'(FRAME_BITS - 1));

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (bit_en) begin
            unique case (st_q)
                ST_SEARCH: if (hit) st_d = ST_VERIFY;
                ST_VERIFY: if (frame_end) begin
                    if (!hit)
                        st_d = ST_SEARCH;
                    else if (hits_q + CNT_W'(1) >= CNT_W'(LOCK_HITS))
                        st_d = ST_LOCKED;
                end
                ST_LOCKED: if (frame_end && !hit &&
                               (miss_q + CNT_W'(1) >= CNT_W'(LOSS_MISS)))
                    st_d = ST_SEARCH;
                default: st_d = ST_SEARCH;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_SEARCH;
        else        st_q <= st_d;
    end

    // window, position and hit/miss counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            pos_q  <= '0;
            hits_q <= '0;
            miss_q <= '0;
        end else if (bit_en) begin
            win_q <= win_nx;
            if (st_q == ST_SEARCH) begin
                pos_q  <= '0;
                hits_q <= CNT_W'(1);
                miss_q <= '0;
            end else begin
                pos_q <= frame_end ? '0 : pos_q + POS_W'(1);
                if (frame_end) begin
                    if (hit) begin
                        miss_q <= '0;
                        if (st_q == ST_VERIFY) hits_q <= hits_q + CNT_W'(1);
                    end else begin
                        miss_q <= miss_q + CNT_W'(1);
                    end
                end
            end
        end
    end

    assign locked = (st_q == ST_LOCKED);
    assign pos    = pos_q;
endmodule

// File: rtl/nicam_prbs.sv
module nicam_prbs #(
    parameter int PRBS_W   = 9,
    parameter int PRBS_TAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    output logic key
);
    logic [PRBS_W-1:0] st_q, cur;

    assign cur = restart ? '1 : st_q;
    assign key = cur[PRBS_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    st_q <= '1;
        else if (step) st_q <= {cur[PRBS_W-2:0], cur[PRBS_W-1] ^ cur[PRBS_TAP-1]};
    end
endmodule

// File: rtl/nicam_flag_track.sv
module nicam_flag_track #(
    parameter int CTRL_W  = 5,
    parameter int PHASE_W = 4,
    parameter int POS_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               locked,
    input  logic               pay_en,
    input  logic               dbit,
    input  logic [POS_W-1:0]   pos,
    output logic [CTRL_W-1:0]  ctrl,
    output logic [PHASE_W-1:0] phase,
    output logic               sync
);
    localparam int HALF = 2 ** (PHASE_W - 1);

    logic               prev_q, sync_q, rise, want;
    logic [PHASE_W-1:0] ph_q, ph_nx;

    for (genvar g = 0; g < CTRL_W; g++) begin : g_ctrl
        logic b_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           b_q <= 1'b0;
            else if (pay_en && pos == POS_W'(g))  b_q <= dbit;
        end
        assign ctrl[g] = b_q;
    end

    assign rise  = ctrl[0] && !prev_q;
    assign ph_nx = rise ? '0 : ph_q + PHASE_W'(1);
    assign want  = (ph_nx < PHASE_W'(HALF));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            ph_q   <= '0;
            sync_q <= 1'b0;
        end else if (!locked) begin
            sync_q <= 1'b0;
        end else if (pay_en && pos == POS_W'(CTRL_W - 1)) begin
            prev_q <= ctrl[0];
            ph_q   <= ph_nx;
            if (rise)                 sync_q <= 1'b1;
            else if (ctrl[0] != want) sync_q <= 1'b0;
        end
    end

    assign phase = ph_q;
    assign sync  = sync_q;
endmodule

// File: rtl/nicam_sample_unit.sv
module nicam_sample_unit #(
    parameter int SMP_W      = 11,
    parameter int SAMP_START = 16,
    parameter int PAY_BITS   = 720,
    parameter int POS_W      = 10,
    parameter int ERR_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pay_en,
    input  logic             dbit,
    input  logic [POS_W-1:0] pos,
    output logic             smp_valid,
    output logic             smp_chan,
    output logic [SMP_W-1:0] smp_word,
    output logic             smp_perr,
    output logic [ERR_W-1:0] frm_errs
);
    localparam int BC_W = $clog2(SMP_W);

    logic [SMP_W-1:0] sh_q, full;
    logic [SMP_W-1:0] good_q [2];
    logic [BC_W-1:0]  bitc_q;
    logic [ERR_W-1:0] acc_q;
    logic             ch_q, in_samp, done, perr, last_bit;

    assign in_samp  = pay_en && (pos >= POS_W'(SAMP_START));
    assign full     = {sh_q[SMP_W-2:0], dbit};
    assign done     = in_samp && (bitc_q == BC_W'(SMP_W - 1));
    assign perr     = ^full;
    assign last_bit = (pos == POS_W'(PAY_BITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            bitc_q    <= '0;
            ch_q      <= 1'b0;
            acc_q     <= '0;
            smp_valid <= 1'b0;
            smp_chan  <= 1'b0;
            smp_word  <= '0;
            smp_perr  <= 1'b0;
            frm_errs  <= '0;
            for (int i = 0; i < 2; i++) good_q[i] <= '0;
        end else begin
            smp_valid <= 1'b0;
            smp_perr  <= 1'b0;
            if (pay_en && pos == '0) begin
                bitc_q <= '0;
                ch_q   <= 1'b0;
            end
            if (in_samp) begin
                sh_q   <= full;
                bitc_q <= done ? '0 : bitc_q + BC_W'(1);
            end
            if (done) begin
                smp_valid <= 1'b1;
                smp_chan  <= ch_q;
                smp_perr  <= perr;
                ch_q      <= ~ch_q;
                smp_word  <= perr ? good_q[ch_q] : full;
                if (!perr) good_q[ch_q] <= full;
                if (last_bit) begin
                    frm_errs <= acc_q + ERR_W'(perr);
                    acc_q    <= '0;
                end else begin
                    acc_q <= acc_q + ERR_W'(perr);
                end
            end
        end
    end
endmodule

// File: rtl/nicam_frame_sync.sv
module nicam_frame_sync #(
    parameter int FRAME_BITS = 728,
    parameter int ALIGN_W    = 8,
    parameter logic [ALIGN_W-1:0] ALIGN_PAT = 8'h4E,
    parameter int CTRL_W     = 5,
    parameter int SKIP_W     = 11,
    parameter int SMP_W      = 11,
    parameter int N_SMP      = 64,
    parameter int LOCK_HITS  = 2,
    parameter int LOSS_MISS  = 3,
    parameter int PRBS_W     = 9,
    parameter int PRBS_TAP   = 4,
    parameter int PHASE_W    = 4,
    localparam int ERR_W     = $clog2(N_SMP + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               bit_in,
    output logic               lock_o,
    output logic               flag_sync,
    output logic [PHASE_W-1:0] frame_phase,
    output logic [CTRL_W-1:0]  ctrl_bits,
    output logic               smp_valid,
    output logic               smp_chan,
    output logic [SMP_W-1:0]   smp_word,
    output logic               smp_perr,
    output logic [ERR_W-1:0]   frm_errs
);
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int PAY_BITS   = FRAME_BITS - ALIGN_W;
    localparam int SAMP_START = CTRL_W + SKIP_W;

    logic [POS_W-1:0] pos;
    logic             pay_en, key, dbit;

    nicam_align_tracker #(
        .FRAME_BITS(FRAME_BITS), .ALIGN_W(ALIGN_W), .ALIGN_PAT(ALIGN_PAT),
        .LOCK_HITS(LOCK_HITS), .LOSS_MISS(LOSS_MISS), .POS_W(POS_W)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .locked(lock_o), .pos(pos)
    );

    assign pay_en = bit_en && lock_o && (pos < POS_W'(PAY_BITS));

    nicam_prbs #(.PRBS_W(PRBS_W), .PRBS_TAP(PRBS_TAP)) u_prbs (
        .clk(clk), .rst_n(rst_n), .restart(pos == '0), .step(pay_en), .key(key)
    );

    assign dbit = bit_in ^ key;

    nicam_flag_track #(.CTRL_W(CTRL_W), .PHASE_W(PHASE_W), .POS_W(POS_W)) u_flag (
        .clk(clk), .rst_n(rst_n), .locked(lock_o), .pay_en(pay_en), .dbit(dbit),
        .pos(pos), .ctrl(ctrl_bits), .phase(frame_phase), .sync(flag_sync)
    );

    nicam_sample_unit #(
        .SMP_W(SMP_W), .SAMP_START(SAMP_START), .PAY_BITS(PAY_BITS),
        .POS_W(POS_W), .ERR_W(ERR_W)
    ) u_smp (
        .clk(clk), .rst_n(rst_n), .pay_en(pay_en), .dbit(dbit), .pos(pos),
        .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_word(smp_word),
        .smp_perr(smp_perr), .frm_errs(frm_errs)
    );
endmodule

// File: rtl/nicam_frame_sync_chk.sv
module nicam_frame_sync_chk #(
    parameter int N_SMP   = 64,
    parameter int PHASE_W = 4,
    parameter int CTRL_W  = 5,
    parameter int ERR_W   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bit_en,
    input logic               lock_o,
    input logic               flag_sync,
    input logic [PHASE_W-1:0] frame_phase,
    input logic [CTRL_W-1:0]  ctrl_bits,
    input logic               smp_valid,
    input logic               smp_perr,
    input logic [ERR_W-1:0]   frm_errs
);
    // R2
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(bit_en));
    // R3
    lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> $past(bit_en));
    // R4
    smp_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> lock_o);
    // R5
    smp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);
    // R6
    perr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_perr |-> smp_valid);
    // R8
    errs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_errs <= ERR_W'(N_SMP));
    // R9
    sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_sync) |-> (frame_phase == '0) && ctrl_bits[0]);
    // R9
    sync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o |=> !flag_sync);
endmodule

bind nicam_frame_sync nicam_frame_sync_chk #(
    .N_SMP(N_SMP), .PHASE_W(PHASE_W), .CTRL_W(CTRL_W), .ERR_W(ERR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .lock_o(lock_o),
    .flag_sync(flag_sync), .frame_phase(frame_phase), .ctrl_bits(ctrl_bits),
    .smp_valid(smp_valid), .smp_perr(smp_perr), .frm_errs(frm_errs)
);

// File: tb/nicam_frame_sync_bench.sv
module nicam_frame_sync_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic        lock_o, flag_sync, smp_valid, smp_chan, smp_perr;
    logic [3:0]  frame_phase;
    logic [4:0]  ctrl_bits;
    logic [10:0] smp_word;
    logic [6:0]  frm_errs;

    int n_chk = 0;
    int n_bad = 0;
    logic [10:0] good [2];

    always #10 clk = ~clk;

    nicam_frame_sync u_nicam_frame_sync (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .lock_o(lock_o), .flag_sync(flag_sync), .frame_phase(frame_phase),
        .ctrl_bits(ctrl_bits), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_word(smp_word), .smp_perr(smp_perr), .frm_errs(frm_errs)
    );

    // entry: kind[10:9] flag[8] errpat[7:6] lock[5] sync[4] phase[3:0]
    // kind 0 good frame, 1 damaged pattern, 2 damaged pattern and blank payload
    localparam logic [10:0] VEC [28] = '{
        {2'd0,1'b0,2'd0,1'b0,1'b0,4'd0},  {2'd0,1'b0,2'd0,1'b1,1'b0,4'd1},
        {2'd0,1'b1,2'd1,1'b1,1'b1,4'd0},  {2'd0,1'b1,2'd0,1'b1,1'b1,4'd1},
        {2'd0,1'b1,2'd2,1'b1,1'b1,4'd2},  {2'd0,1'b1,2'd0,1'b1,1'b1,4'd3},
        {2'd0,1'b1,2'd0,1'b1,1'b1,4'd4},  {2'd0,1'b1,2'd0,1'b1,1'b1,4'd5},
        {2'd0,1'b1,2'd0,1'b1,1'b1,4'd6},  {2'd0,1'b1,2'd0,1'b1,1'b1,4'd7},
        {2'd0,1'b0,2'd3,1'b1,1'b1,4'd8},  {2'd0,1'b0,2'd0,1'b1,1'b1,4'd9},
        {2'd0,1'b0,2'd0,1'b1,1'b1,4'd10}, {2'd0,1'b0,2'd0,1'b1,1'b1,4'd11},
        {2'd0,1'b0,2'd0,1'b1,1'b1,4'd12}, {2'd0,1'b0,2'd0,1'b1,1'b1,4'd13},
        {2'd0,1'b0,2'd0,1'b1,1'b1,4'd14}, {2'd0,1'b0,2'd0,1'b1,1'b1,4'd15},
        {2'd0,1'b1,2'd0,1'b1,1'b1,4'd0},  {2'd0,1'b0,2'd0,1'b1,1'b0,4'd1},
        {2'd1,1'b0,2'd0,1'b1,1'b0,4'd2},  {2'd1,1'b0,2'd1,1'b1,1'b0,4'd3},
        {2'd0,1'b0,2'd0,1'b1,1'b0,4'd4},  {2'd1,1'b0,2'd0,1'b1,1'b0,4'd5},
        {2'd1,1'b0,2'd0,1'b1,1'b0,4'd6},  {2'd2,1'b0,2'd0,1'b0,1'b0,4'd0},
        {2'd0,1'b0,2'd0,1'b0,1'b0,4'd0},  {2'd0,1'b0,2'd3,1'b1,1'b0,4'd7}
    };

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    function automatic bit err_at(input int pat, input int w);
        case (pat)
            1: return w == 9;
            2: return (w == 20) || (w == 22);
            3: return (w == 0) || (w == 31) || (w == 63);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [10:0] word_of(input int f, input int w, input bit bad);
        logic [9:0] d;
        d = 10'((w * 53 + f * 29 + 7) & 1023);
        return {d, (^d) ^ bad};
    endfunction

    task automatic send_frame(input int f, input int kind, input bit c0, input int pat,
                              input bit lk, input bit sy, input int ph);
        logic [8:0]  s;
        logic [7:0]  pat8;
        logic [10:0] wv, ex;
        logic [4:0]  exp_ctrl;
        logic        d;
        int nvalid, bad, nerr, w, j;
        pat8 = (kind == 0) ? 8'h4E : 8'h00;
        for (int i = 7; i >= 0; i--) put_bit(pat8[i]);
        s = 9'h1FF; nvalid = 0; bad = 0; nerr = 0;
        exp_ctrl = {5'((f & 15) << 1)} | {4'd0, c0};
        for (int p = 0; p < 720; p++) begin
            w = 0; j = 0; wv = '0;
            if (p < 5)       d = exp_ctrl[p];
            else if (p < 16) d = 1'((f + p) & 1);
            else begin
                w  = (p - 16) / 11;
                j  = (p - 16) % 11;
                wv = word_of(f, w, err_at(pat, w));
                d  = wv[10 - j];
            end
            put_bit((kind == 2) ? 1'b0 : (d ^ s[8]));
            s = {s[7:0], s[8] ^ s[3]};
            if (smp_valid) nvalid++;
            if (p >= 16 && j == 10 && lk) begin
                if (err_at(pat, w)) begin
                    ex = good[w & 1];
                    nerr++;
                end else begin
                    ex = wv;
                    good[w & 1] = wv;
                end
                if (!(smp_valid && smp_chan == 1'(w & 1) && smp_word == ex &&
                      smp_perr == err_at(pat, w))) begin
                    bad++;
                    $display("FAIL R7/R6 frame %0d word %0d: actual %0d perr %0d expected %0d perr %0d",
                             f, w, smp_word, smp_perr, ex, err_at(pat, w));
                end
            end
        end
        chk(lock_o == lk, $sformatf("R2/R3 lock frame %0d", f), lock_o, lk);
        chk(nvalid == (lk ? 64 : 0), $sformatf("R4/R5 word count frame %0d", f), nvalid, lk ? 64 : 0);
        chk(bad == 0, $sformatf("R6/R7 words frame %0d", f), bad, 0);
        if (lk) begin
            chk(frm_errs == 7'(nerr), $sformatf("R8 errors frame %0d", f), frm_errs, nerr);
            chk(ctrl_bits == exp_ctrl, $sformatf("R5 control frame %0d", f), ctrl_bits, exp_ctrl);
            chk(flag_sync == sy, $sformatf("R9 sync frame %0d", f), flag_sync, sy);
            chk(frame_phase == 4'(ph), $sformatf("R9 phase frame %0d", f), frame_phase, ph);
        end
    endtask

    task automatic reset_and_check();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        good[0] = '0; good[1] = '0;
        chk(!lock_o && !flag_sync && !smp_valid && !smp_perr, "R10 flags", lock_o, 0);
        chk(frame_phase == 0 && ctrl_bits == 0, "R10 phase/ctrl", frame_phase, 0);
        chk(frm_errs == 0, "R10 errors", frm_errs, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        reset_and_check();
        for (int f = 0; f < 28; f++)
            send_frame(f, int'(VEC[f][10:9]), VEC[f][8], int'(VEC[f][7:6]),
                       VEC[f][5], VEC[f][4], int'(VEC[f][3:0]));
        // R10 reset in mid-stream, then R1 odd alignment and R7 concealment from reset value
        reset_and_check();
        repeat (3) put_bit(1'b1);
        send_frame(40, 0, 1'b0, 0, 1'b0, 1'b0, 0);
        send_frame(41, 0, 1'b1, 3, 1'b1, 1'b1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule